// File: doc/BRIEF.md
# USB Device Receive Status Queue

This block holds the per-event status words of a full-speed USB device receive path. For every receive event the packet engine hands over a set of fields: endpoint, byte count, data PID, packet status code, low frame bits and a status-phase marker. The block packs them into one 32-bit word and queues it. An event is a data packet, a completed transfer, a SETUP stage or a global OUT NAK. Status codes that mean nothing are refused at the push side and never reach the queue.

Software reads the queue through a register-style port with two addresses. One address gives a non-destructive look at the oldest word. The other gives the same word and removes it. A level output is high while any word is waiting. A one-cycle interrupt strobe flags queued events that need attention. A sticky overflow flag records pushes that were lost because the queue was full. A read of an empty queue returns zero and changes nothing.

Top module: `rxstat_queue`

## Requirements
- R1: Each queued word is packed as: ep in bits 3:0, byte count in bits 14:4, data PID in bits 16:15, status code in bits 20:17, frame low bits in bits 24:21, status-phase flag in bit 27. Bits 31:28 and 26:25 are always zero.
- R2: Valid status codes are 4'h1 (global OUT NAK), 4'h2 (OUT data), 4'h3 (OUT transfer done), 4'h4 (SETUP done) and 4'h6 (SETUP data). A push carrying any other code writes no entry, does not raise the interrupt and does not set overflow.
- R3: `irq` is high for exactly the one cycle after the clock edge that accepts a push with code 4'h1, 4'h3 or 4'h4. Codes 4'h2 and 4'h6 never raise it.
- R4: The status-phase bit (bit 27) of a stored word is set only when `push_phase_start` is high and the code is 4'h3. With any other code the bit is stored as zero.
- R5: While `rd_en` is high with `rd_addr` = 8'h1C (peek), `rd_data` shows the oldest entry in the same cycle, and the queue contents and count are left unchanged.
- R6: While `rd_en` is high with `rd_addr` = 8'h20 (pop), `rd_data` shows the oldest entry in the same cycle, and that entry is removed at the next clock edge.
- R7: A read while the queue is empty returns 32'h0 and changes no state. A read at any address other than 8'h1C or 8'h20 also returns 32'h0 and changes no state.
- R8: `count` equals the number of stored entries, and `level` is high exactly when `count` is non-zero. After reset both are zero.
- R9: A valid push while the queue holds DEPTH entries, and no pop is made in the same cycle, is dropped and sets `overflow`. `overflow` stays set until reset.
- R10: A push and a pop in the same cycle are both performed and `count` is unchanged. This holds when the queue is full, and in that case no overflow occurs.
- R11: Entries leave the queue in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Push request for one status word |
| push_ep | input | 4 | Endpoint number |
| push_bcnt | input | 11 | Received byte count |
| push_pid | input | 2 | Data PID (2'b00 DATA0, 2'b10 DATA1) |
| push_sts | input | 4 | Packet status code |
| push_frame | input | 4 | Low bits of the frame number |
| push_phase_start | input | 1 | Status stage of a control write begins |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register byte offset (8'h1C peek, 8'h20 pop) |
| rd_data | output | 32 | Read data, combinational |
| level | output | 1 | Queue holds at least one entry |
| count | output | CW | Number of stored entries |
| irq | output | 1 | One-cycle strobe for attention events |
| overflow | output | 1 | Sticky flag for lost pushes |

## Verification
A read or write pointer that moves wrongly shows up at the next peek or pop as a word out of order, or as a word that repeats. A count that drifts shows up on `level` one clock after the faulty update, and at the latest when the queue should read as empty but still returns data. If a reserved code slips through, or the phase bit is not masked, the error appears in `rd_data` as soon as that word reaches the head. A misdecoded status code shows as a wrong or missing `irq` strobe in the very next cycle.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

   typedef enum logic [3:0] {
      STS_GLOBAL_NAK = 4'h1,
      STS_OUT_DATA   = 4'h2,
      STS_OUT_DONE   = 4'h3,
      STS_SETUP_DONE = 4'h4,
      STS_SETUP_DATA = 4'h6
   } rx_sts_e;

   typedef struct packed {
      logic [3:0]  zero_hi;
      logic        phase_start;
      logic [1:0]  zero_mid;
      logic [3:0]  frame;
      logic [3:0]  sts;
      logic [1:0]  pid;
      logic [10:0] bcnt;
      logic [3:0]  ep;
   } rx_word_t;

   function automatic logic sts_known(input logic [3:0] code);
      return code inside {STS_GLOBAL_NAK, STS_OUT_DATA, STS_OUT_DONE,
                          STS_SETUP_DONE, STS_SETUP_DATA};
   endfunction

   function automatic logic sts_alerts(input logic [3:0] code);
      return code inside {STS_GLOBAL_NAK, STS_OUT_DONE, STS_SETUP_DONE};
   endfunction

endpackage

// File: rtl/rxstat_pack.sv
module rxstat_pack
   import rxstat_pkg::*;
(
   input  logic [3:0]  ep,
   input  logic [10:0] bcnt,
   input  logic [1:0]  pid,
   input  logic [3:0]  sts,
   input  logic [3:0]  frame,
   input  logic        phase_start,
   output rx_word_t    word,
   output logic        known,
   output logic        alert
);

   always_comb begin
      word             = '0;
      word.ep          = ep;
      word.bcnt        = bcnt;
      word.pid         = pid;
      word.sts         = sts;
      word.frame       = frame;
      word.phase_start = phase_start && (sts == STS_OUT_DONE);
      known            = sts_known(sts);
      alert            = sts_alerts(sts);
   end

endmodule

// File: rtl/rxstat_store.sv
module rxstat_store #(
   parameter int DEPTH = 8,
   parameter int W     = 32,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [W-1:0]  wr_data,
   input  logic          rd_pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] cnt_q;

   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem_q[g] <= '0;
            else if (wr_en && (wr_ptr == AW'(g)))
               mem_q[g] <= wr_data;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_en)  wr_ptr <= wr_nxt;
         if (rd_pop) rd_ptr <= rd_nxt;
         case ({wr_en, rd_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign head  = mem_q[rd_ptr];
   assign count = cnt_q;
   assign full  = (cnt_q == CW'(DEPTH));
   assign empty = (cnt_q == '0);

endmodule

// File: rtl/rxstat_queue.sv
module rxstat_queue
   import rxstat_pkg::*;
#(
   parameter int         DEPTH     = 8,
   parameter int         RAW       = 8,
   parameter logic [7:0] POP_ADDR  = 8'h20,
   parameter logic [7:0] PEEK_ADDR = 8'h1C,
   localparam int        CW        = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push_valid,
   input  logic [3:0]     push_ep,
   input  logic [10:0]    push_bcnt,
   input  logic [1:0]     push_pid,
   input  logic [3:0]     push_sts,
   input  logic [3:0]     push_frame,
   input  logic           push_phase_start,
   input  logic           rd_en,
   input  logic [RAW-1:0] rd_addr,
   output logic [31:0]    rd_data,
   output logic           level,
   output logic [CW-1:0]  count,
   output logic           irq,
   output logic           overflow
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rxstat_queue: DEPTH must be at least 2");
      end
      if (RAW < 8) begin : g_bad_raw
         $error("rxstat_queue: RAW must cover the read offsets");
      end
   endgenerate

   rx_word_t      pk_word;
   logic          pk_known, pk_alert;
   logic [31:0]   head;
   logic          full, empty;
   logic          sel_pop, sel_peek, pop_fire, push_take;
   logic          irq_q, ovf_q;

   rxstat_pack u_pack (
      .ep          (push_ep),
      .bcnt        (push_bcnt),
      .pid         (push_pid),
      .sts         (push_sts),
      .frame       (push_frame),
      .phase_start (push_phase_start),
      .word        (pk_word),
      .known       (pk_known),
      .alert       (pk_alert)
   );

   assign sel_pop   = rd_en && (rd_addr == RAW'(POP_ADDR));
   assign sel_peek  = rd_en && (rd_addr == RAW'(PEEK_ADDR));
   assign pop_fire  = sel_pop && !empty;
   assign push_take = push_valid && pk_known && (!full || pop_fire);

   rxstat_store #(.DEPTH(DEPTH), .W(32)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push_take),
      .wr_data (pk_word),
      .rd_pop  (pop_fire),
      .head    (head),
      .count   (count),
      .full    (full),
      .empty   (empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         irq_q <= push_take && pk_alert;
         if (push_valid && pk_known && full && !pop_fire)
            ovf_q <= 1'b1;
      end
   end

   assign rd_data  = ((sel_pop || sel_peek) && !empty) ? head : 32'h0;
   assign level    = !empty;
   assign irq      = irq_q;
   assign overflow = ovf_q;

endmodule

// File: rtl/rxstat_queue_chk.sv
module rxstat_queue_chk #(
   parameter int         DEPTH     = 8,
   parameter int         RAW       = 8,
   parameter logic [7:0] POP_ADDR  = 8'h20,
   parameter logic [7:0] PEEK_ADDR = 8'h1C,
   localparam int        CW        = $clog2(DEPTH + 1)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           push_valid,
   input logic [3:0]     push_sts,
   input logic           rd_en,
   input logic [RAW-1:0] rd_addr,
   input logic [31:0]    rd_data,
   input logic           level,
   input logic [CW-1:0]  count,
   input logic           irq,
   input logic           overflow
);

   logic at_pop, at_peek, code_ok, code_irq;
   assign at_pop   = rd_en && (rd_addr == RAW'(POP_ADDR));
   assign at_peek  = rd_en && (rd_addr == RAW'(PEEK_ADDR));
   assign code_ok  = (push_sts == 4'h1) || (push_sts == 4'h2) || (push_sts == 4'h3) ||
                     (push_sts == 4'h4) || (push_sts == 4'h6);
   assign code_irq = (push_sts == 4'h1) || (push_sts == 4'h3) || (push_sts == 4'h4);

   AST_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[31:28] == 4'h0) && (rd_data[26:25] == 2'b00)); // R1
   AST_RESERVED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && !code_ok && !at_pop) |=> $stable(count)); // R2
   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(push_valid && code_irq)); // R3
   AST_PHASE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[27] |-> (rd_data[20:17] == 4'h3)); // R4
   AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (at_peek && !push_valid) |=> $stable(count)); // R5
   AST_POP_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (at_pop && level && !push_valid) |=> (count == $past(count) - 1'b1)); // R6
   AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !level) |-> (rd_data == 32'h0)); // R7
   AST_LEVEL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(level) |-> $past(push_valid)); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R8
   AST_FULL_PUSH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && code_ok && (count == CW'(DEPTH)) && !at_pop) |=> overflow); // R9
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow); // R9
   AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && code_ok && at_pop && level) |=> $stable(count)); // R10

endmodule

bind rxstat_queue rxstat_queue_chk #(
   .DEPTH(DEPTH), .RAW(RAW), .POP_ADDR(POP_ADDR), .PEEK_ADDR(PEEK_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_valid (push_valid),
   .push_sts   (push_sts),
   .rd_en      (rd_en),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .level      (level),
   .count      (count),
   .irq        (irq),
   .overflow   (overflow)
);

// File: tb/sim_rxstat_queue.sv
module sim_rxstat_queue;

   localparam int D  = 8;
   localparam int CW = $clog2(D + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic push_valid = 1'b0;
   logic [3:0]  push_ep = '0;
   logic [10:0] push_bcnt = '0;
   logic [1:0]  push_pid = '0;
   logic [3:0]  push_sts = '0;
   logic [3:0]  push_frame = '0;
   logic        push_phase_start = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        level, irq, overflow;
   logic [CW-1:0] count;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] mq[$];
   bit exp_ovf = 0;

   always #2 clk = ~clk;

   rxstat_queue #(.DEPTH(D)) u0 (.*);

   typedef struct packed {
      logic        pv;
      logic [3:0]  ep;
      logic [10:0] bcnt;
      logic [1:0]  pid;
      logic [3:0]  sts;
      logic [3:0]  frm;
      logic        ps;
      logic        rd;
      logic [7:0]  addr;
      logic [3:0]  exp_cnt;
      logic        exp_irq;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 4'd1, 11'd64, 2'b00, 4'h2, 4'd3, 1'b0, 1'b0, 8'h00, 4'd1, 1'b0},
      '{1'b1, 4'd2, 11'd0,  2'b00, 4'h3, 4'd4, 1'b1, 1'b0, 8'h00, 4'd2, 1'b1},
      '{1'b0, 4'd0, 11'd0,  2'b00, 4'h0, 4'd0, 1'b0, 1'b1, 8'h1C, 4'd2, 1'b0},
      '{1'b0, 4'd0, 11'd0,  2'b00, 4'h0, 4'd0, 1'b0, 1'b1, 8'h20, 4'd1, 1'b0},
      '{1'b1, 4'd5, 11'd3,  2'b00, 4'h7, 4'd1, 1'b0, 1'b0, 8'h00, 4'd1, 1'b0},
      '{1'b1, 4'd0, 11'd8,  2'b00, 4'h4, 4'd5, 1'b0, 1'b1, 8'h20, 4'd1, 1'b1},
      '{1'b1, 4'd3, 11'd8,  2'b10, 4'h6, 4'd6, 1'b0, 1'b0, 8'h00, 4'd2, 1'b0},
      '{1'b1, 4'd4, 11'd12, 2'b10, 4'h1, 4'd7, 1'b1, 1'b0, 8'h00, 4'd3, 1'b1},
      '{1'b0, 4'd0, 11'd0,  2'b00, 4'h0, 4'd0, 1'b0, 1'b1, 8'h24, 4'd3, 1'b0},
      '{1'b0, 4'd0, 11'd0,  2'b00, 4'h0, 4'd0, 1'b0, 1'b1, 8'h20, 4'd2, 1'b0},
      '{1'b0, 4'd0, 11'd0,  2'b00, 4'h0, 4'd0, 1'b0, 1'b1, 8'h20, 4'd1, 1'b0},
      '{1'b0, 4'd0, 11'd0,  2'b00, 4'h0, 4'd0, 1'b0, 1'b1, 8'h20, 4'd0, 1'b0},
      '{1'b0, 4'd0, 11'd0,  2'b00, 4'h0, 4'd0, 1'b0, 1'b1, 8'h20, 4'd0, 1'b0},
      '{1'b0, 4'd0, 11'd0,  2'b00, 4'h0, 4'd0, 1'b0, 1'b1, 8'h1C, 4'd0, 1'b0},
      '{1'b1, 4'd6, 11'd9,  2'b00, 4'h0, 4'd2, 1'b0, 1'b0, 8'h00, 4'd0, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pack_ref(vec_t v);
      return {4'h0, v.ps && (v.sts == 4'h3), 2'b00, v.frm, v.sts, v.pid, v.bcnt, v.ep};
   endfunction

   function automatic bit code_ref(logic [3:0] s);
      return s == 4'h1 || s == 4'h2 || s == 4'h3 || s == 4'h4 || s == 4'h6;
   endfunction

   // One bus cycle: drive, check rd_data before the edge, update model, check after the edge.
   task automatic step(input vec_t v, input bit chk_tbl);
      logic [31:0] exp_rd;
      bit popped, took, exp_irq;
      @(negedge clk);
      push_valid = v.pv; push_ep = v.ep; push_bcnt = v.bcnt; push_pid = v.pid;
      push_sts = v.sts; push_frame = v.frm; push_phase_start = v.ps;
      rd_en = v.rd; rd_addr = v.addr;
      #1;
      exp_rd = (v.rd && (v.addr == 8'h20 || v.addr == 8'h1C) && mq.size() > 0) ? mq[0] : 32'h0;
      check("R5/R6/R7/R11 rd_data", rd_data, exp_rd);
      popped = v.rd && v.addr == 8'h20 && mq.size() > 0;
      if (popped) void'(mq.pop_front());
      took = v.pv && code_ref(v.sts) && mq.size() < D;
      if (took) mq.push_back(pack_ref(v));
      if (v.pv && code_ref(v.sts) && !took) exp_ovf = 1;
      exp_irq = took && (v.sts == 4'h1 || v.sts == 4'h3 || v.sts == 4'h4);
      @(posedge clk);
      #1;
      push_valid = 1'b0; rd_en = 1'b0;
      check("R8 count", 32'(count), 32'(mq.size()));
      check("R8 level", 32'(level), 32'(mq.size() != 0));
      check("R3 irq", 32'(irq), 32'(exp_irq));
      check("R9 overflow", 32'(overflow), 32'(exp_ovf));
      if (chk_tbl) begin
         check("R2/R10 table count", 32'(count), 32'(v.exp_cnt));
         check("R3 table irq", 32'(irq), 32'(v.exp_irq));
      end
   endtask

   function automatic vec_t mk(bit pv, logic [10:0] bcnt, logic [3:0] sts, bit rd, logic [7:0] addr);
      vec_t v = '0;
      v.pv = pv; v.ep = bcnt[3:0]; v.bcnt = bcnt; v.sts = sts; v.frm = bcnt[7:4];
      v.rd = rd; v.addr = addr;
      return v;
   endfunction

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R8 R9 R3: reset state
      rd_en = 1'b1; rd_addr = 8'h1C; #1;
      check("R7 reset peek", rd_data, 32'h0);
      rd_en = 1'b0;
      check("R8 reset count", 32'(count), 0);
      check("R8 reset level", 32'(level), 0);
      check("R3 reset irq", 32'(irq), 0);
      check("R9 reset overflow", 32'(overflow), 0);
      @(negedge clk); rst_n = 1'b1;

      // Table walk: R1 R2 R3 R4 R5 R6 R7 R10 R11
      for (int i = 0; i < NV; i++) step(VEC[i], 1'b1);

      // R9: fill to DEPTH, one more push is dropped
      for (int i = 0; i < D; i++) step(mk(1'b1, 11'(16 * i + 1), 4'h2, 1'b0, 8'h00), 1'b0);
      check("R9 full count", 32'(count), D);
      step(mk(1'b1, 11'd1000, 4'h4, 1'b0, 8'h00), 1'b0);
      check("R9 overflow set", 32'(overflow), 1);
      // R10: push and pop together while full
      step(mk(1'b1, 11'd777, 4'h3, 1'b1, 8'h20), 1'b0);
      check("R10 full push+pop count", 32'(count), D);
      // R5: repeated peek keeps head
      step(mk(1'b0, 11'd0, 4'h0, 1'b1, 8'h1C), 1'b0);
      step(mk(1'b0, 11'd0, 4'h0, 1'b1, 8'h1C), 1'b0);
      // R11: drain in order
      for (int i = 0; i < D; i++) step(mk(1'b0, 11'd0, 4'h0, 1'b1, 8'h20), 1'b0);
      check("R9 overflow sticky", 32'(overflow), 1);
      // R7: pop on empty with no push changes nothing
      step(mk(1'b0, 11'd0, 4'h0, 1'b1, 8'h20), 1'b0);

      // R9: reset clears overflow
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R9 overflow cleared", 32'(overflow), 0);
      rst_n = 1'b1;
      mq.delete(); exp_ovf = 0;
      step(mk(1'b1, 11'd5, 4'h6, 1'b0, 8'h00), 1'b0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule